// File: doc/BRIEF.md
# Serial Port with Flow Control

This block is a byte-wide asynchronous serial port. It has one transmitter and one receiver, and software drives both through a small register window on a plain read/write bus. A 16-bit control and status word holds all settings and flags. A second address takes the byte to transmit. A third address returns the last byte received. Frames carry 8 data bits, least significant bit first, with no parity. A fixed clock divider sets the bit period.

Flow control works in two ways. Hardware handshaking holds back the transmitter until the clear-to-send input is active. It also drives a request-to-send output that tells the far end whether the receive register has room. The polarity of each of these two pins can be chosen. Software handshaking watches the received bytes for 0x13 (pause) and 0x11 (resume) and keeps a read-only paused flag. When software handshaking is enabled, that flag holds back the transmitter. One interrupt output combines a receive-ready source with the transmit-done and receive-done sources, and each group has its own mask.

Top module: `sport_ctl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000, `txd_o` is 1, `irq_o` is 0 and `rts_o` is 0.
- R2: While bit 15 (port enable) is 0, a byte written to address 1 is not transmitted and `txd_o` stays 1. A frame arriving on `rxd_i` is not received: bit 0 stays 0.
- R3: A transmitted frame is one low start bit, then 8 data bits LSB first, then a high stop period, each bit DIV clocks long. Bit 5 = 1 gives one stop bit and bit 5 = 0 gives two. Bit 7 (transmit done) sets when the last stop bit ends.
- R4: The receiver samples each bit at its middle and accepts a frame whatever the number of stop bits. The byte appears at address 2 bits 7:0, and bit 0 (receive ready) and bit 6 (receive done) set. A read of address 2 clears bit 0.
- R5: If a frame completes while bit 0 is set, the new byte is discarded and bit 2 (overflow) sets. The read of address 2 returns the older byte and clears bit 2.
- R6: Writing 1 to bit 7 or bit 6 of the control word clears that flag. Writing 0 leaves it unchanged.
- R7: With bit 10 set, no new frame starts while CTS is inactive. Bit 13 = 0 means `cts_i` high is active, and bit 13 = 1 means `cts_i` low is active.
- R8: RTS is active while the port is enabled and bit 0 is clear, and inactive otherwise. Bit 14 = 0 drives active as `rts_o` = 1, and bit 14 = 1 drives active as `rts_o` = 0.
- R9: A received 0x13 sets bit 12 and a received 0x11 clears it. With bit 11 set and bit 12 set, no new frame starts.
- R10: `irq_o` = (bit 9 AND bit 0) OR (bit 8 AND (bit 7 OR bit 6)).
- R11: Bit 4 (transmit ready) is 1 while the port is enabled and no byte waits to start, and 0 after a byte is written until its frame starts. Writes to the read-only bits 12, 4, 2, 1, 0 have no effect, and bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for the read side effect at address 2) |
| bus_addr | input | 2 | 0 = control word, 1 = transmit byte, 2 = received byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| txd_o | output | 1 | Serial transmit line, idle high |
| rxd_i | input | 1 | Serial receive line, idle high |
| rts_o | output | 1 | Request-to-send, level set by bit 14 |
| cts_i | input | 1 | Clear-to-send, level set by bit 13 |
| irq_o | output | 1 | Combined interrupt |

## Verification
A written byte starts at the next baud tick, which comes at most DIV clocks later. The bench therefore waits for the falling start edge within a bounded window of cycles. After that edge it samples every bit at its middle, DIV/2 plus a whole number of DIV clocks later. A received byte is due about half a bit plus three clocks after the stop bit begins, because of two synchronizer stages and the mid-bit count. The bench reads the flags only after a full stop bit has passed. The transmit-done flag sets exactly 10 or 11 bit times after the start edge. The bench reads it at 10.5 bit times, so one stop bit and two stop bits give opposite values with half a bit of margin either side. The flags for W1C, RTS and the interrupt follow a write or read by one clock, and the bench checks them at the next falling edge.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam logic [7:0] CH_RESUME = 8'h11;
  localparam logic [7:0] CH_PAUSE  = 8'h13;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_TXB = 2'd1;
  localparam logic [1:0] A_RXB = 2'd2;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  // pin level -> logical active, given an active-low select
  function automatic logic pin_active(input logic pin, input logic act_low);
    return pin ^ act_low;
  endfunction

  // clocks from the start edge to the start bit's middle
  function automatic int unsigned half_bit(input int unsigned div);
    return (div / 2 > 0) ? div / 2 : 1;
  endfunction
endpackage

// File: rtl/sport_baud.sv
module sport_baud #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       go,
  input  logic [7:0] data,
  input  logic       two_stop,
  output logic       start,
  output logic       done,
  output logic       txd
);
  tx_st_e     st;
  logic [7:0] sh;
  logic [2:0] nbit;
  logic       extra;

  assign start = run && tick && (st == TX_IDLE) && go;
  assign done  = run && tick && (st == TX_STOP) && !extra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; sh <= '0; nbit <= '0; extra <= 1'b0; txd <= 1'b1;
    end else if (!run) begin
      st <= TX_IDLE; nbit <= '0; extra <= 1'b0; txd <= 1'b1;
    end else if (tick) begin
      unique case (st)
        TX_IDLE: if (go) begin
          st <= TX_START; sh <= data; extra <= two_stop; txd <= 1'b0;
        end
        TX_START: begin
          txd <= sh[0]; sh <= sh >> 1; nbit <= '0; st <= TX_DATA;
        end
        TX_DATA: begin
          if (nbit == 3'd7) begin
            txd <= 1'b1; st <= TX_STOP;
          end else begin
            txd <= sh[0]; sh <= sh >> 1; nbit <= nbit + 1'b1;
          end
        end
        TX_STOP: begin
          if (extra) extra <= 1'b0;
          else       st <= TX_IDLE;
        end
      endcase
    end
  end

  // R3: the line is high whenever no frame is in progress
  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_IDLE) |-> txd);
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int unsigned DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rxd,
  output logic       fin,
  output logic [7:0] data
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = half_bit(DIV);

  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic [7:0]    sh;
  logic          mid;

  assign mid  = (cnt == '0);
  assign fin  = run && (st == RX_STOP) && mid && rxd;
  assign data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; nbit <= '0; sh <= '0;
    end else if (!run) begin
      st <= RX_IDLE; cnt <= '0; nbit <= '0;
    end else begin
      unique case (st)
        RX_IDLE: if (!rxd) begin
          st <= RX_START; cnt <= CW'(HALF - 1);
        end
        RX_START: begin
          if (!mid)     cnt <= cnt - 1'b1;
          else if (!rxd) begin st <= RX_DATA; cnt <= CW'(DIV - 1); nbit <= '0; end
          else          st <= RX_IDLE;
        end
        RX_DATA: begin
          if (!mid) cnt <= cnt - 1'b1;
          else begin
            sh  <= {rxd, sh[7:1]};
            cnt <= CW'(DIV - 1);
            if (nbit == 3'd7) st <= RX_STOP;
            else              nbit <= nbit + 1'b1;
          end
        end
        RX_STOP: begin
          if (!mid) cnt <= cnt - 1'b1;
          else      st <= RX_IDLE;
        end
      endcase
    end
  end

  // R4: a completed frame always leaves the receiver idle next cycle
  a_r4_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (st == RX_IDLE));
endmodule

// File: rtl/sport_ctl.sv
module sport_ctl
  import sport_pkg::*;
#(
  parameter int unsigned DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic        rts_o,
  input  logic        cts_i,
  output logic        irq_o
);
  // settings
  logic en, rts_low, cts_low, pause_en, hw_en, rx_ie, done_ie, one_stop, pkt_sel;
  // flags and data
  logic       paused, tx_done_f, rx_done_f, rx_rdy, rx_ovf, tx_pend;
  logic [7:0] tx_hold, rx_buf;
  logic [1:0] rx_sync, cts_sync;

  // internal events
  logic       wr_ctl, wr_txb, rd_rxb, tick, tx_start, tx_fin, rx_fin;
  logic [7:0] rx_byte;
  logic       cts_on, flow_ok, accept, ovf_ev;

  assign wr_ctl  = bus_wr && (bus_addr == A_CTL);
  assign wr_txb  = bus_wr && (bus_addr == A_TXB);
  assign rd_rxb  = bus_rd && (bus_addr == A_RXB);
  assign cts_on  = pin_active(cts_sync[1], cts_low);
  assign flow_ok = (!hw_en || cts_on) && !(pause_en && paused);
  assign accept  = rx_fin && (!rx_rdy || rd_rxb);
  assign ovf_ev  = rx_fin && rx_rdy && !rd_rxb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11; cts_sync <= 2'b00;
    end else begin
      rx_sync <= {rx_sync[0], rxd_i}; cts_sync <= {cts_sync[0], cts_i};
    end
  end

  sport_baud #(.DIV(DIV)) u_baud (.clk(clk), .rst_n(rst_n), .run(en), .tick(tick));

  sport_tx u_tx (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick), .go(tx_pend && flow_ok),
    .data(tx_hold), .two_stop(!one_stop), .start(tx_start), .done(tx_fin), .txd(txd_o)
  );

  sport_rx #(.DIV(DIV)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(en), .rxd(rx_sync[1]), .fin(rx_fin), .data(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, rts_low, cts_low, pause_en, hw_en, rx_ie, done_ie, one_stop, pkt_sel} <= '0;
    end else if (wr_ctl) begin
      en <= bus_wdata[15]; rts_low <= bus_wdata[14]; cts_low <= bus_wdata[13];
      pause_en <= bus_wdata[11]; hw_en <= bus_wdata[10]; rx_ie <= bus_wdata[9];
      done_ie <= bus_wdata[8]; one_stop <= bus_wdata[5]; pkt_sel <= bus_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0; tx_hold <= '0;
    end else if (!en || tx_start) begin
      tx_pend <= 1'b0;
    end else if (wr_txb && !tx_pend) begin
      tx_pend <= 1'b1; tx_hold <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done_f <= 1'b0; rx_done_f <= 1'b0;
    end else begin
      if (tx_fin)                        tx_done_f <= 1'b1;
      else if (wr_ctl && bus_wdata[7])   tx_done_f <= 1'b0;
      if (rx_fin)                        rx_done_f <= 1'b1;
      else if (wr_ctl && bus_wdata[6])   rx_done_f <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0; rx_ovf <= 1'b0; rx_buf <= '0; paused <= 1'b0;
    end else begin
      if (accept) begin rx_rdy <= 1'b1; rx_buf <= rx_byte; end
      else if (rd_rxb) rx_rdy <= 1'b0;
      if (ovf_ev)      rx_ovf <= 1'b1;
      else if (rd_rxb) rx_ovf <= 1'b0;
      if (rx_fin && rx_byte == CH_PAUSE)       paused <= 1'b1;
      else if (rx_fin && rx_byte == CH_RESUME) paused <= 1'b0;
    end
  end

  assign rts_o = (en && !rx_rdy) ^ rts_low;
  assign irq_o = (rx_ie && rx_rdy) || (done_ie && (tx_done_f || rx_done_f));

  always_comb begin
    unique case (bus_addr)
      A_CTL:   bus_rdata = {en, rts_low, cts_low, paused, pause_en, hw_en, rx_ie, done_ie,
                            tx_done_f, rx_done_f, one_stop, en && !tx_pend, pkt_sel,
                            rx_ovf, 1'b0, rx_rdy};
      A_RXB:   bus_rdata = {8'h00, rx_buf};
      default: bus_rdata = 16'h0000;
    endcase
  end

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd_o);
  a_r7_cts_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (!hw_en || cts_on));
  a_r9_pause_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !(pause_en && paused));
  a_r5_overflow_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ($stable(rx_buf) && rx_ovf));
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[7] && !tx_fin) |=> !tx_done_f);
  a_r8_rts_off_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy |-> (rts_o == rts_low));
endmodule

// File: tb/sport_ctl_test.sv
module sport_ctl_test;
  localparam int DIV = 16;
  localparam logic [15:0] EN = 16'h8000, RTSL = 16'h4000, CTSL = 16'h2000,
    PEN = 16'h0800, HWEN = 16'h0400, RIE = 16'h0200, DIE = 16'h0100,
    TXD_F = 16'h0080, RXD_F = 16'h0040, ONE = 16'h0020;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic txd_o, rxd_i = 1'b1, rts_o, cts_i = 1'b0, irq_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  sport_ctl #(.DIV(DIV)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int nstop);
    @(negedge clk); rxd_i = 1'b0; idle(DIV);
    for (int i = 0; i < 8; i++) begin rxd_i = b[i]; idle(DIV); end
    rxd_i = 1'b1; idle(DIV * nstop);
  endtask

  // waits for a start edge; returns the byte and the stop-bit level
  task automatic grab(output logic got, output logic [7:0] b, output logic stp);
    got = 1'b0; b = '0; stp = 1'b0;
    for (int i = 0; i < 4 * DIV && !got; i++) begin
      @(negedge clk); if (!txd_o) got = 1'b1;
    end
    if (got) begin
      idle(DIV / 2);
      for (int i = 0; i < 8; i++) begin idle(DIV); b[i] = txd_o; end
      idle(DIV); stp = txd_o;
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); chk("R1 ctl", d, 16'h0000);
    chk("R1 txd", {15'd0, txd_o}, 16'd1);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 rts", {15'd0, rts_o}, 16'd0);
  endtask

  task automatic t_off;
    logic [15:0] d; logic g, s; logic [7:0] b;
    wr(2'd1, 16'h00A5); grab(g, b, s); chk("R2 no tx", {15'd0, g}, 16'd0);
    send(8'h5C, 1); rd(2'd0, d); chk("R2 no rx", d & 16'h0041, 16'h0000);
  endtask

  task automatic t_tx;
    logic [15:0] d; logic g, s; logic [7:0] b;
    wr(2'd0, EN | ONE); rd(2'd0, d); chk("R11 ready", d & 16'h0010, 16'h0010);
    wr(2'd1, 16'h005A); grab(g, b, s);
    chk("R3 byte", {8'h0, b}, 16'h005A); chk("R3 stop", {15'd0, s}, 16'd1);
    idle(DIV - 2); rd(2'd0, d); chk("R3 one stop done", d & TXD_F, TXD_F);
    wr(2'd0, EN | ONE); rd(2'd0, d); chk("R6 write0 keeps", d & TXD_F, TXD_F);
    wr(2'd0, EN | ONE | TXD_F); rd(2'd0, d); chk("R6 write1 clears", d & TXD_F, 16'h0);
    wr(2'd0, EN); wr(2'd1, 16'h00C3); grab(g, b, s);
    chk("R3 byte2", {8'h0, b}, 16'h00C3);
    idle(DIV - 2); rd(2'd0, d); chk("R3 two stop not yet", d & TXD_F, 16'h0);
    idle(DIV); rd(2'd0, d); chk("R3 two stop done", d & TXD_F, TXD_F);
    wr(2'd0, EN | TXD_F);
  endtask

  task automatic t_rx;
    logic [15:0] d;
    wr(2'd0, EN); send(8'h96, 1); idle(4);
    rd(2'd0, d); chk("R4 flags", d & 16'h0041, 16'h0041);
    rd(2'd2, d); chk("R4 data", d, 16'h0096);
    rd(2'd0, d); chk("R4 ready cleared", d & 16'h0001, 16'h0);
    send(8'h3C, 2); rd(2'd2, d); chk("R4 two stop rx", d, 16'h003C);
    send(8'h71, 1); idle(4); rd(2'd2, d); chk("R4 one stop rx", d, 16'h0071);
    wr(2'd0, EN | RXD_F); rd(2'd0, d); chk("R6 rx done clear", d & RXD_F, 16'h0);
  endtask

  task automatic t_ovf;
    logic [15:0] d;
    send(8'hAA, 1); send(8'h55, 1); idle(4);
    rd(2'd0, d); chk("R5 ovf set", d & 16'h0005, 16'h0005);
    rd(2'd2, d); chk("R5 old kept", d, 16'h00AA);
    rd(2'd0, d); chk("R5 ovf cleared", d & 16'h0005, 16'h0);
  endtask

  task automatic t_rts;
    logic [15:0] d;
    chk("R8 active high", {15'd0, rts_o}, 16'd1);
    send(8'h42, 1); idle(4); chk("R8 full", {15'd0, rts_o}, 16'd0);
    rd(2'd2, d); @(negedge clk); chk("R8 emptied", {15'd0, rts_o}, 16'd1);
    wr(2'd0, EN | RTSL); @(negedge clk); chk("R8 active low", {15'd0, rts_o}, 16'd0);
    wr(2'd0, EN | RXD_F);
  endtask

  task automatic t_cts;
    logic [15:0] d; logic g, s; logic [7:0] b;
    cts_i = 1'b0; wr(2'd0, EN | HWEN | ONE); wr(2'd1, 16'h000F);
    grab(g, b, s); chk("R7 held high-pol", {15'd0, g}, 16'd0);
    rd(2'd0, d); chk("R11 not ready", d & 16'h0010, 16'h0);
    cts_i = 1'b1; grab(g, b, s); chk("R7 released", {7'd0, g, b}, 16'h010F);
    wr(2'd0, EN | HWEN | CTSL | ONE | TXD_F); wr(2'd1, 16'h00E1);
    grab(g, b, s); chk("R7 held low-pol", {15'd0, g}, 16'd0);
    cts_i = 1'b0; grab(g, b, s); chk("R7 low-pol go", {7'd0, g, b}, 16'h01E1);
    idle(2 * DIV); wr(2'd0, EN | ONE | TXD_F);
  endtask

  task automatic t_pause;
    logic [15:0] d; logic g, s; logic [7:0] b;
    wr(2'd0, EN | PEN | ONE); send(8'h13, 1); idle(4); rd(2'd2, d);
    rd(2'd0, d); chk("R9 paused", d & 16'h1000, 16'h1000);
    wr(2'd1, 16'h0024); grab(g, b, s); chk("R9 held", {15'd0, g}, 16'd0);
    send(8'h11, 1); rd(2'd2, d);
    grab(g, b, s); chk("R9 resumed", {7'd0, g, b}, 16'h0124);
    idle(2 * DIV);
    wr(2'd0, EN | ONE | TXD_F | RXD_F | 16'h1017);
    rd(2'd0, d); chk("R11 read-only", d & 16'h1017, 16'h0010);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    wr(2'd0, EN | RIE); @(negedge clk); chk("R10 quiet", {15'd0, irq_o}, 16'd0);
    send(8'h66, 1); idle(4); chk("R10 rx ready", {15'd0, irq_o}, 16'd1);
    rd(2'd2, d); @(negedge clk); chk("R10 read drops", {15'd0, irq_o}, 16'd0);
    wr(2'd0, EN | DIE); @(negedge clk); chk("R10 done src", {15'd0, irq_o}, 16'd1);
    wr(2'd0, EN | DIE | RXD_F); @(negedge clk); chk("R10 cleared", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    t_reset(); t_off(); t_tx(); t_rx(); t_ovf(); t_rts();
    t_cts(); t_pause(); t_irq();
    finish_up();
  end
endmodule